// File: doc/BRIEF.md
# Prescaled PWM Timer Channel

This block is one pulse-width-modulation timer channel. A 16-bit up-counter runs from zero to a programmable period and then wraps. A compare value sets the tick at which the output becomes active. Each cycle the count advances by one step of a prescaled time base. That time base is either the system clock or a pulse stream that marks edges of an external clock, and a power-of-four divider slows it down.

Software drives the channel through a small register port with a write strobe, an address, write data and combinational read data. The control register sets these things:
- the divider setting
- the time-base source
- whether the counter runs
- whether the pin is driven
- the pin polarity
- how a disable takes effect: at once, or at the end of the current period

Software can also load the counter directly. This gives a clean restart: stop the output, load zero, write the new compare values, then enable again.

Top module: `pwm_timer_chan`

## Requirements
- R1: After reset, every register reads zero and `pwm_out` is 0.
- R2: Address 0 is control, address 1 the count, address 2 the period, address 3 the compare value. The control bits are: [2:0] divider setting, [3] external source, [4] output enable, [5] active-low, [6] immediate shutdown, [7] counter run. Bits [15:8] of control read as zero, and writes to them are ignored.
- R3: With the system clock as source, setting s advances the count once every 4^s cycles while the counter runs. Settings 6 and 7 behave like 5, which divides by 1024.
- R4: On each count step the counter increments. When the count is already at or above the period, the step returns it to zero instead. With a period of zero the count stays at zero.
- R5: While the output is enabled, the pin is active whenever the count is at or above the effective compare value, and inactive below it.
- R6: A compare value equal to or above the period acts as period minus one. With a period of zero it acts as zero.
- R7: A write to the count loads that value in the next cycle and takes priority over a count step. It also restarts the divider phase.
- R8: While the run bit is clear, the count holds and the divider phase returns to zero. Setting the bit again resumes counting from the held value.
- R9: With the active-low bit set, the pin level is inverted: the inactive level is 1 and the active level is 0.
- R10: Clearing the output enable while the immediate-shutdown bit is set drives the pin to its inactive level right after the write's clock edge.
- R11: Clearing the output enable while immediate shutdown is clear lets the waveform continue until the next wrap to zero, after which the pin stays inactive. Setting the enable again resumes the waveform at once.
- R12: With the external source selected, the divider advances only in cycles where `ext_tick` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_tick | input | 1 | One-cycle pulse per external clock edge, already synchronous to clk |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data for the register at `reg_addr` |
| pwm_out | output | 1 | PWM pin |

## Verification
The assertions check the following on every cycle:
- the wrap to zero after a step at the period
- the counter holding while the run bit is clear
- full-rate counting at divider setting zero
- the pin sitting at the inactive level whenever the output gate is shut
- the gate being open whenever the enable is set
- the one-edge response of an immediate shutdown

Only the bench's scenarios can show the rest:
- the exact high and low tick counts of the waveform
- the compare clamp
- the deferred shutdown that waits for the end of a period
- the slow divider settings, including the out-of-range settings that clamp to 5
- gating by the external source
- the priority of a count write

The bench compares these cycle by cycle against its own model.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;

    localparam int PS_W   = 3;
    localparam int PS_MAX = 5;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] ADDR_CTRL   = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_COUNT  = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_PERIOD = 2'd2;
    localparam logic [ADDR_W-1:0] ADDR_CMP    = 2'd3;

    // Control word, MSB first: bit 7 run down to bits 2:0 divider setting
    typedef struct packed {
        logic            run;
        logic            sudden_off;
        logic            act_low;
        logic            out_en;
        logic            src_ext;
        logic [PS_W-1:0] div_sel;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
    import pwm_timer_pkg::*;
#(
    parameter int SEL_W   = PS_W,
    parameter int SEL_MAX = PS_MAX
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             src_ext,
    input  logic             ext_tick,
    input  logic [SEL_W-1:0] div_sel,
    input  logic             restart,
    output logic             step
);
    localparam int DIV_W = 2 * SEL_MAX;

    typedef struct packed {
        logic [DIV_W-1:0] phase;
    } pre_state_t;

    pre_state_t st_d, st_q;

    // Terminal phase for each divider setting: 4^g - 1
    logic [DIV_W-1:0] term [0:SEL_MAX];

    for (genvar g = 0; g <= SEL_MAX; g++) begin : g_term
        assign term[g] = DIV_W'((64'd1 << (2 * g)) - 64'd1);
    end

    logic [SEL_W-1:0] sel_eff;
    logic             src_pulse;

    always_comb begin
        st_d      = st_q;
        step      = 1'b0;
        sel_eff   = (int'(div_sel) > SEL_MAX) ? SEL_W'(SEL_MAX) : div_sel;
        src_pulse = src_ext ? ext_tick : 1'b1;
        if (!run || restart) begin
            st_d.phase = '0;
        end else if (src_pulse) begin
            if (st_q.phase >= term[sel_eff]) begin
                st_d.phase = '0;
                step       = 1'b1;
            end else begin
                st_d.phase = st_q.phase + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_d,
    output logic             wrap
);
    always_comb begin
        cnt_d = cnt_q;
        wrap  = 1'b0;
        if (load) begin
            cnt_d = load_val;
        end else if (step) begin
            if (cnt_q >= period) begin
                cnt_d = '0;
                wrap  = 1'b1;
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/pwm_out_stage.sv
module pwm_out_stage #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             out_en,
    input  logic             sudden_off,
    input  logic             act_low,
    input  logic             wrap,
    input  logic [CNT_W-1:0] cnt_nxt,
    input  logic [CNT_W-1:0] period_nxt,
    input  logic [CNT_W-1:0] cmp_nxt,
    output logic             gate_q,
    output logic             pin_q
);
    typedef struct packed {
        logic gate;
        logic pin;
    } out_state_t;

    out_state_t st_d, st_q;
    logic [CNT_W-1:0] cmp_eff;
    logic             active;

    always_comb begin
        if (cmp_nxt >= period_nxt)
            cmp_eff = (period_nxt == '0) ? '0 : period_nxt - 1'b1;
        else
            cmp_eff = cmp_nxt;

        st_d = st_q;
        if (out_en)          st_d.gate = 1'b1;
        else if (sudden_off) st_d.gate = 1'b0;
        else if (wrap)       st_d.gate = 1'b0;

        active   = (cnt_nxt >= cmp_eff);
        st_d.pin = (st_d.gate & active) ^ act_low;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign gate_q = st_q.gate;
    assign pin_q  = st_q.pin;

endmodule

// File: rtl/pwm_timer_chan.sv
module pwm_timer_chan
    import pwm_timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_tick,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [CNT_W-1:0]  reg_wdata,
    output logic [CNT_W-1:0]  reg_rdata,
    output logic              pwm_out
);
    typedef struct packed {
        ctrl_t            ctrl;
        logic [CNT_W-1:0] period;
        logic [CNT_W-1:0] cmp;
    } regs_t;

    regs_t            regs_d, regs_q;
    logic             cnt_load;
    logic             step;
    logic             wrap;
    logic             gate;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        regs_d   = regs_q;
        cnt_load = reg_we && (reg_addr == ADDR_COUNT);
        if (reg_we) begin
            case (reg_addr)
                ADDR_CTRL:   regs_d.ctrl   = ctrl_t'(reg_wdata[CTRL_W-1:0]);
                ADDR_PERIOD: regs_d.period = reg_wdata;
                ADDR_CMP:    regs_d.cmp    = reg_wdata;
                default:     ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        case (reg_addr)
            ADDR_CTRL:   reg_rdata = CNT_W'(regs_q.ctrl);
            ADDR_COUNT:  reg_rdata = cnt_q;
            ADDR_PERIOD: reg_rdata = regs_q.period;
            default:     reg_rdata = regs_q.cmp;
        endcase
    end

    pwm_prescaler #(
        .SEL_W   (PS_W),
        .SEL_MAX (PS_MAX)
    ) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (regs_q.ctrl.run),
        .src_ext  (regs_q.ctrl.src_ext),
        .ext_tick (ext_tick),
        .div_sel  (regs_q.ctrl.div_sel),
        .restart  (cnt_load),
        .step     (step)
    );

    pwm_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (step),
        .load     (cnt_load),
        .load_val (reg_wdata),
        .period   (regs_q.period),
        .cnt_q    (cnt_q),
        .cnt_d    (cnt_d),
        .wrap     (wrap)
    );

    pwm_out_stage #(
        .CNT_W (CNT_W)
    ) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .out_en     (regs_d.ctrl.out_en),
        .sudden_off (regs_d.ctrl.sudden_off),
        .act_low    (regs_d.ctrl.act_low),
        .wrap       (wrap),
        .cnt_nxt    (cnt_d),
        .period_nxt (regs_d.period),
        .cmp_nxt    (regs_d.cmp),
        .gate_q     (gate),
        .pin_q      (pwm_out)
    );

endmodule

// File: rtl/pwm_timer_chan_chk.sv
module pwm_timer_chan_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_we,
    input logic [1:0]       reg_addr,
    input logic [CNT_W-1:0] reg_wdata,
    input logic             pwm_out,
    input logic [7:0]       ctrl_q,
    input logic             gate_q,
    input logic [CNT_W-1:0] cnt_q,
    input logic [CNT_W-1:0] per_q,
    input logic             step
);
    logic cnt_wr;
    assign cnt_wr = reg_we && (reg_addr == 2'd1);

    AST_SUDDEN_OFF_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == 2'd0 && !reg_wdata[4] && reg_wdata[6]) |=> (pwm_out == $past(reg_wdata[5]))); // R10

    AST_SHUT_GATE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate_q) |-> (pwm_out == ctrl_q[5])); // R9

    AST_ENABLE_OPENS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q[4] |-> gate_q); // R11

    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (step && cnt_q >= per_q && !cnt_wr) |=> (cnt_q == '0)); // R4

    AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q[7] && !cnt_wr) |=> $stable(cnt_q)); // R8

    AST_FULL_RATE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[7] && ctrl_q[2:0] == 3'd0 && !ctrl_q[3] && cnt_q < per_q && !cnt_wr)
        |=> (cnt_q == $past(cnt_q) + 1'b1)); // R3

endmodule

bind pwm_timer_chan pwm_timer_chan_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .pwm_out   (pwm_out),
    .ctrl_q    (regs_q.ctrl),
    .gate_q    (gate),
    .cnt_q     (cnt_q),
    .per_q     (regs_q.period),
    .step      (step)
);

// File: tb/pwm_timer_chan_bench.sv
module pwm_timer_chan_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext_tick = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [15:0] reg_wdata = 16'd0;
    logic [15:0] reg_rdata;
    logic        pwm_out;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    pwm_timer_chan u_pwm_timer_chan (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_tick  (ext_tick),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .pwm_out   (pwm_out)
    );

    // Bench model of the channel
    logic [2:0]  m_ps;
    logic        m_src, m_oe, m_pol, m_abr, m_run;
    logic [15:0] m_cnt, m_per, m_cmp;
    int          m_div;
    logic        m_gate, m_out;

    function automatic logic [15:0] m_read(input logic [1:0] a);
        case (a)
            2'd0:    return {8'd0, m_run, m_abr, m_pol, m_oe, m_src, m_ps};
            2'd1:    return m_cnt;
            2'd2:    return m_per;
            default: return m_cmp;
        endcase
    endfunction

    function automatic void model_step(input logic we, input logic [1:0] a,
                                       input logic [15:0] d, input logic ext);
        int   lim;
        logic cw, tk, wr;
        logic [15:0] ce;
        lim = 1 << (2 * ((m_ps > 3'd5) ? 5 : int'(m_ps)));
        cw  = we && (a == 2'd1);
        tk  = 1'b0;
        wr  = 1'b0;
        if (!m_run || cw) m_div = 0;
        else if (!m_src || ext) begin
            if (m_div >= lim - 1) begin m_div = 0; tk = 1'b1; end
            else m_div++;
        end
        if (cw) m_cnt = d;
        else if (tk) begin
            wr    = (m_cnt >= m_per);
            m_cnt = wr ? 16'd0 : m_cnt + 16'd1;
        end
        if (we) begin
            case (a)
                2'd0: {m_run, m_abr, m_pol, m_oe, m_src, m_ps} = d[7:0];
                2'd2: m_per = d;
                2'd3: m_cmp = d;
                default: ;
            endcase
        end
        if (m_oe)       m_gate = 1'b1;
        else if (m_abr) m_gate = 1'b0;
        else if (wr)    m_gate = 1'b0;
        if (m_cmp >= m_per) ce = (m_per == 16'd0) ? 16'd0 : m_per - 16'd1;
        else                ce = m_cmp;
        m_out = (m_gate & (m_cnt >= ce)) ^ m_pol;
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic step(input logic we, input logic [1:0] a, input logic [15:0] d,
                        input logic ext, input string tag);
        @(negedge clk);
        reg_we = we; reg_addr = a; reg_wdata = d; ext_tick = ext;
        model_step(we, a, d, ext);
        @(posedge clk);
        #1;
        chk(tag, "pwm_out", {15'd0, pwm_out}, {15'd0, m_out});
        chk(tag, "rdata", reg_rdata, m_read(a));
    endtask

    task automatic idle(input int n, input logic [1:0] a, input string tag);
        for (int i = 0; i < n; i++) step(1'b0, a, 16'd0, 1'b0, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        m_ps = 0; m_src = 0; m_oe = 0; m_pol = 0; m_abr = 0; m_run = 0;
        m_cnt = 0; m_per = 0; m_cmp = 0; m_div = 0; m_gate = 0; m_out = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        #1;
        chk("R1", "pwm_out", {15'd0, pwm_out}, 16'd0);
        for (int a = 0; a < 4; a++) begin
            step(1'b0, 2'(a), 16'd0, 1'b0, "R1");
            chk("R1", "reset_reg", reg_rdata, 16'd0);
        end
        // R2: control layout and unused bits
        step(1'b1, 2'd0, 16'hFF3C, 1'b0, "R2");
        chk("R2", "ctrl_read", reg_rdata, 16'h003C);
        step(1'b1, 2'd0, 16'h0000, 1'b0, "R2");
        // R4 R5: period 4, compare 2, full rate
        step(1'b1, 2'd2, 16'd4, 1'b0, "R4");
        step(1'b1, 2'd3, 16'd2, 1'b0, "R5");
        step(1'b1, 2'd1, 16'd0, 1'b0, "R7");
        step(1'b1, 2'd0, 16'h0090, 1'b0, "R5");
        idle(12, 2'd1, "R4");
        // R6: compare above period clamps
        step(1'b1, 2'd3, 16'd9, 1'b0, "R6");
        idle(10, 2'd1, "R6");
        step(1'b1, 2'd2, 16'd0, 1'b0, "R4");
        idle(6, 2'd1, "R4");
        chk("R4", "zero_period_cnt", reg_rdata, 16'd0);
        step(1'b1, 2'd2, 16'd5, 1'b0, "R4");
        step(1'b1, 2'd3, 16'd3, 1'b0, "R5");
        // R9: polarity
        step(1'b1, 2'd0, 16'h00B0, 1'b0, "R9");
        idle(12, 2'd1, "R9");
        step(1'b1, 2'd0, 16'h0090, 1'b0, "R9");
        // R11: deferred shutdown, then re-enable
        step(1'b1, 2'd1, 16'd4, 1'b0, "R7");
        step(1'b1, 2'd0, 16'h0080, 1'b0, "R11");
        idle(10, 2'd1, "R11");
        chk("R11", "off_after_wrap", {15'd0, pwm_out}, 16'd0);
        step(1'b1, 2'd0, 16'h0090, 1'b0, "R11");
        idle(8, 2'd1, "R11");
        // R10: immediate shutdown from active region
        step(1'b1, 2'd1, 16'd4, 1'b0, "R7");
        step(1'b1, 2'd0, 16'h00C0, 1'b0, "R10");
        chk("R10", "pin_inactive", {15'd0, pwm_out}, 16'd0);
        idle(4, 2'd1, "R10");
        step(1'b1, 2'd0, 16'h00E0, 1'b0, "R10");
        chk("R10", "pin_inactive_low", {15'd0, pwm_out}, 16'd1);
        // R3: divider settings
        step(1'b1, 2'd0, 16'h0091, 1'b0, "R3");
        idle(30, 2'd1, "R3");
        step(1'b1, 2'd2, 16'd1, 1'b0, "R3");
        step(1'b1, 2'd3, 16'd0, 1'b0, "R3");
        step(1'b1, 2'd0, 16'h0097, 1'b0, "R3");
        idle(2100, 2'd1, "R3");
        step(1'b1, 2'd0, 16'h0092, 1'b0, "R3");
        step(1'b1, 2'd2, 16'd3, 1'b0, "R3");
        idle(70, 2'd1, "R3");
        // R12: external source
        step(1'b1, 2'd0, 16'h0098, 1'b0, "R12");
        for (int i = 0; i < 40; i++) step(1'b0, 2'd1, 16'd0, 1'($urandom % 2), "R12");
        step(1'b0, 2'd1, 16'd0, 1'b0, "R12");
        begin
            logic [15:0] held;
            held = reg_rdata;
            idle(10, 2'd1, "R12");
            chk("R12", "no_ext_hold", reg_rdata, held);
        end
        // R8: stop and resume
        step(1'b1, 2'd0, 16'h0010, 1'b0, "R8");
        idle(8, 2'd1, "R8");
        step(1'b1, 2'd0, 16'h0090, 1'b0, "R8");
        idle(8, 2'd1, "R8");
        // R7: load while running
        step(1'b1, 2'd1, 16'd2, 1'b0, "R7");
        chk("R7", "loaded", reg_rdata, 16'd2);
        idle(5, 2'd1, "R7");
        // Random mix, fixed seed
        void'($urandom(32'd1234));
        for (int i = 0; i < 4000; i++) begin
            logic [1:0]  a;
            logic [15:0] d;
            logic        we;
            a  = 2'($urandom % 4);
            we = ($urandom % 5) == 0;
            case (a)
                2'd0: d = {8'($urandom), 1'b1, 2'($urandom), 1'b1, 1'($urandom),
                           ($urandom % 8 < 6) ? 3'($urandom % 2) : 3'($urandom)};
                2'd1: d = 16'($urandom % 16);
                2'd2: d = 16'($urandom % 13);
                default: d = 16'($urandom % 16);
            endcase
            if (a == 2'd0 && ($urandom % 4) == 0) d[7] = 1'b0;
            if (a == 2'd0 && ($urandom % 4) == 0) d[4] = 1'b0;
            step(we, a, d, 1'($urandom % 2), "R5");
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule